// File: doc/BRIEF.md
# Continuous Four-Channel SAR Scan Controller

This block is the digital sequencer of a successive-approximation converter that is shared by four analog inputs. Once its run input is high it never stops. It visits the channels in the fixed order 0, 1, 2, 3 and then starts again at 0. Every channel gets a slot of equal length. A slot opens with a sampling window, during which the sample-and-hold gate is driven open. Then come eight bit trials, most significant bit first. Each trial drives a code to the external DAC and reads back a single comparator bit. The slot ends with idle time, so a full scan of all four channels repeats at a fixed period.

Each channel's 8-bit result is written into a byte of one of two 16-bit result words. A new result always replaces the old one, whether or not software has read it. At the end of every scan, when the fourth channel finishes, two interrupt request flags are raised together. Software clears each flag by writing a one to its bit. A small register interface also holds a 4-bit mask. The mask enables the digital input buffer on each of the shared pins, and the pin levels it lets through can be read back.

All timing derives from the parameter `CYC_PER_US`, the number of clock cycles per microsecond. With the default slot of 12 µs and a sampling window of 2 µs, one scan takes 48 µs.

Top module: `scan_sar_ctrl`

## Requirements
- R1: After reset the following are all zero: both result words, both flags, the mask and `pin_dig_en`. `mux_sel` is 0, `sh_gate` is low and `sar_code` is 0.
- R2: While `run` is low, the scan stays parked at the start of channel 0 with `sh_gate` low and `sar_code` 0, and the result words are unchanged. In the first cycle after `run` rises, channel 0 sampling begins.
- R3: Channels are converted in the order 0, 1, 2, 3, 0, and so on. `mux_sel` holds one channel for a whole slot of SLOT_US*CYC_PER_US cycles.
- R4: `sh_gate` is high for the first SAMPLE_US*CYC_PER_US cycles of every slot and low for the rest of it. `sar_code` is 0 while the gate is open.
- R5: The trials run MSB first, and the first trial code is 8'h80. At the last cycle of each trial, the trial bit is kept if `cmp_in` is 1 (input ≥ DAC) and is cleared otherwise. The next lower bit is then set. For a comparator that is true whenever the input is at or above the code, the result equals the input level.
- R6: Read address 0 returns {channel 1, channel 0} and read address 1 returns {channel 3, channel 2}, with the lower channel in bits [7:0]. A byte changes only when its own channel's conversion completes.
- R7: Every completed conversion overwrites its byte, whether or not the word has been read.
- R8: Both flags are set in the same cycle. That cycle is the one right after the clock edge that decides channel 3's last bit. The flags appear on `irq_flag` and in bits [1:0] of read address 2.
- R9: A write to address 2 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 alone. If a scan ends in the same cycle as a clear, the set wins.
- R10: A write to address 3 loads the mask from data bits [3:0], and the mask drives `pin_dig_en`. Read address 3 returns the mask in bits [3:0] and `dig_in & mask` in bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Continuous scan enable |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC code |
| dig_in | input | 4 | Digital levels of the shared pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| mux_sel | output | 2 | Analog input select |
| sh_gate | output | 1 | Sample-and-hold gate, high = open |
| sar_code | output | 8 | Trial code to the DAC |
| irq_flag | output | 2 | End-of-scan request flags |
| pin_dig_en | output | 4 | Per-pin digital input buffer enable |

## Verification
The assertions assume that `rst_n` is low at time zero. They also assume that the bus write inputs are only meaningful while `wr_en` is high, and that `run` changes only between clock edges. The comparator in the bench is a combinational model, true while the selected channel's level is at or above `sar_code`. The bench changes a channel's level only after that channel has finished converting in the current scan, so every trial sees a steady input. Flag clears are timed against the slot counts derived from the parameters, and that is how the same-cycle set and clear case is reached.

// File: rtl/sar_scan_pkg.sv
// Shared constants and types for the four-channel SAR scan controller.
// Assumes exactly four channels, packed two per 16-bit result word.
package sar_scan_pkg;
    localparam int NCH      = 4;
    localparam int CH_W     = 2;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int MASK_W   = 4;

    localparam logic [ADDR_W-1:0] A_RES_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_RES_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd2;
    localparam logic [ADDR_W-1:0] A_MASK   = 2'd3;

    typedef enum logic [1:0] {
        PH_SAMPLE = 2'd0,
        PH_TRIAL  = 2'd1,
        PH_IDLE   = 2'd2
    } phase_t;
endpackage

// File: rtl/sar_slot_timer.sv
// Slot sequencer: steps through sample, trial and idle phases for each channel
// and advances the channel round-robin. Assumes every phase length is >= 1.
module sar_slot_timer
    import sar_scan_pkg::*;
#(
    parameter int SAMPLE_CYC = 20,
    parameter int TRIAL_CYC  = 11,
    parameter int IDLE_CYC   = 12,
    parameter int BITS       = 8,
    localparam int CNT_W     = $clog2(SAMPLE_CYC + TRIAL_CYC + IDLE_CYC + 1),
    localparam int BIT_W     = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CH_W-1:0]  ch,
    output logic             sh_gate,
    output logic             load_p,
    output logic             decide_p,
    output logic [BIT_W-1:0] bit_idx
);
    phase_t           phase;
    logic [CNT_W-1:0] pcnt;

    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] T_LAST = CNT_W'(TRIAL_CYC - 1);
    localparam logic [CNT_W-1:0] I_LAST = CNT_W'(IDLE_CYC - 1);

    // Phase, phase counter, bit index and channel state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase   <= PH_SAMPLE;
            pcnt    <= '0;
            bit_idx <= '0;
            ch      <= '0;
        end else begin
            case (phase)
                PH_SAMPLE: begin
                    if (pcnt == S_LAST) begin
                        phase   <= PH_TRIAL;
                        pcnt    <= '0;
                        bit_idx <= BIT_W'(BITS - 1);
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                PH_TRIAL: begin
                    if (pcnt == T_LAST) begin
                        pcnt <= '0;
                        if (bit_idx == '0) phase <= PH_IDLE;
                        else               bit_idx <= bit_idx - 1'b1;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                default: begin
                    if (pcnt == I_LAST) begin
                        phase <= PH_SAMPLE;
                        pcnt  <= '0;
                        ch    <= ch + 1'b1;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Phase-decoded strobes for the gate and the trial register.
    always_comb begin
        sh_gate  = run && (phase == PH_SAMPLE);
        load_p   = run && (phase == PH_SAMPLE) && (pcnt == S_LAST);
        decide_p = run && (phase == PH_TRIAL) && (pcnt == T_LAST);
    end
endmodule

// File: rtl/sar_trial_reg.sv
// Successive-approximation register: loads the MSB trial, resolves one bit per
// decide strobe from the comparator, and emits the finished byte as a pulse.
// Assumes decide strobes arrive with bit_idx counting down from BITS-1 to 0.
module sar_trial_reg
    import sar_scan_pkg::*;
#(
    parameter int BITS   = 8,
    localparam int BIT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load_p,
    input  logic             decide_p,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [CH_W-1:0]  ch,
    input  logic             cmp_in,
    output logic [BITS-1:0]  code,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_ch,
    output logic [BITS-1:0]  res_data
);
    localparam logic [BITS-1:0] ONE = BITS'(1);

    logic [BITS-1:0] this_bit;
    logic [BITS-1:0] resolved;

    // Bit under trial and the code after resolving it.
    always_comb begin
        this_bit = ONE << bit_idx;
        resolved = cmp_in ? code : (code & ~this_bit);
    end

    // Trial code register and finished-result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            code      <= '0;
            res_valid <= 1'b0;
            res_ch    <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (load_p) begin
                code <= ONE << (BITS - 1);
            end else if (decide_p) begin
                if (bit_idx == '0) begin
                    code      <= '0;
                    res_valid <= 1'b1;
                    res_ch    <= ch;
                    res_data  <= resolved;
                end else begin
                    code <= resolved | (this_bit >> 1);
                end
            end
        end
    end
endmodule

// File: rtl/scan_result_bank.sv
// Result bytes, end-of-scan flags, pin-enable mask and read mux.
// Assumes res_valid is a one-cycle pulse carrying the finished channel.
module scan_result_bank
    import sar_scan_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [BITS-1:0]   res_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [MASK_W-1:0] dig_in,
    output logic [WORD_W-1:0] rd_data,
    output logic [1:0]        irq_flag,
    output logic [MASK_W-1:0] pin_dig_en
);
    logic [BITS-1:0] res_byte [NCH];
    logic            scan_end;
    logic [1:0]      clr;

    // One byte register per channel, written only by its own conversion.
    for (genvar g = 0; g < NCH; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)                                 res_byte[g] <= '0;
            else if (res_valid && res_ch == CH_W'(g))   res_byte[g] <= res_data;
        end
    end

    // End-of-scan event and write-one-to-clear decode.
    always_comb begin
        scan_end = res_valid && (res_ch == CH_W'(NCH - 1));
        clr      = (wr_en && wr_addr == A_FLAGS) ? wr_data[1:0] : 2'b00;
    end

    // Flags: a scan end beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_flag <= 2'b00;
        else if (scan_end) irq_flag <= 2'b11;
        else               irq_flag <= irq_flag & ~clr;
    end

    // Digital input enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pin_dig_en <= '0;
        else if (wr_en && wr_addr == A_MASK) pin_dig_en <= wr_data[MASK_W-1:0];
    end

    // Readback multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RES_LO: rd_data = {res_byte[1], res_byte[0]};
            A_RES_HI: rd_data = {res_byte[3], res_byte[2]};
            A_FLAGS:  rd_data[1:0] = irq_flag;
            default:  rd_data[2*MASK_W-1:0] = {dig_in & pin_dig_en, pin_dig_en};
        endcase
    end
endmodule

// File: rtl/scan_sar_ctrl.sv
// Top of the continuous four-channel SAR scan controller. Derives the slot
// layout from CYC_PER_US and wires timer, trial register and result bank.
// Assumes SLOT_US leaves room for sampling, BITS trials and idle time.
module scan_sar_ctrl
    import sar_scan_pkg::*;
#(
    parameter int CYC_PER_US = 10,
    parameter int SAMPLE_US  = 2,
    parameter int SLOT_US    = 12,
    parameter int BITS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cmp_in,
    input  logic [3:0]        dig_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic [1:0]        mux_sel,
    output logic              sh_gate,
    output logic [BITS-1:0]   sar_code,
    output logic [1:0]        irq_flag,
    output logic [3:0]        pin_dig_en
);
    localparam int SLOT_CYC   = SLOT_US * CYC_PER_US;
    localparam int SAMPLE_CYC = SAMPLE_US * CYC_PER_US;
    localparam int TRIAL_CYC  = (SLOT_CYC - SAMPLE_CYC) / (BITS + 1);
    localparam int IDLE_CYC   = SLOT_CYC - SAMPLE_CYC - BITS * TRIAL_CYC;
    localparam int BIT_W      = $clog2(BITS);

    logic             load_p;
    logic             decide_p;
    logic [BIT_W-1:0] bit_idx;
    logic             res_valid;
    logic [CH_W-1:0]  res_ch;
    logic [BITS-1:0]  res_data;

    sar_slot_timer #(
        .SAMPLE_CYC(SAMPLE_CYC), .TRIAL_CYC(TRIAL_CYC),
        .IDLE_CYC(IDLE_CYC), .BITS(BITS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .ch(mux_sel), .sh_gate(sh_gate),
        .load_p(load_p), .decide_p(decide_p), .bit_idx(bit_idx)
    );

    sar_trial_reg #(.BITS(BITS)) u_trial (
        .clk(clk), .rst_n(rst_n), .run(run), .load_p(load_p),
        .decide_p(decide_p), .bit_idx(bit_idx), .ch(mux_sel), .cmp_in(cmp_in),
        .code(sar_code), .res_valid(res_valid), .res_ch(res_ch),
        .res_data(res_data)
    );

    scan_result_bank #(.BITS(BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ch(res_ch),
        .res_data(res_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .dig_in(dig_in),
        .rd_data(rd_data), .irq_flag(irq_flag), .pin_dig_en(pin_dig_en)
    );
endmodule

// File: rtl/scan_sar_ctrl_chk.sv
// Property checker for scan_sar_ctrl, attached by bind below.
// Assumes rst_n is low from time zero.
module scan_sar_ctrl_chk #(
    parameter int BITS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            wr_en,
    input logic [1:0]      wr_addr,
    input logic [15:0]     wr_data,
    input logic [1:0]      mux_sel,
    input logic            sh_gate,
    input logic [BITS-1:0] sar_code,
    input logic [1:0]      irq_flag,
    input logic [3:0]      pin_dig_en
);
    p_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (mux_sel == 2'd0 && sar_code == '0));

    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && mux_sel != $past(mux_sel))
            |-> mux_sel == $past(mux_sel) + 2'd1);

    p_gate_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_gate |-> sar_code == '0);

    p_flags_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag[0]) |-> irq_flag[1]);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag[0] && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> irq_flag[0]);

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd3) |=> $stable(pin_dig_en));
endmodule

bind scan_sar_ctrl scan_sar_ctrl_chk #(.BITS(BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mux_sel(mux_sel), .sh_gate(sh_gate),
    .sar_code(sar_code), .irq_flag(irq_flag), .pin_dig_en(pin_dig_en)
);

// File: tb/scan_sar_ctrl_tb_top.sv
module scan_sar_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CPU    = 4;
    localparam int S_CYC  = 2 * CPU;
    localparam int SLOT   = 12 * CPU;
    localparam int T_CYC  = (SLOT - S_CYC) / 9;
    localparam int FLAG_C = S_CYC + 8 * T_CYC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  dig_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  mux_sel;
    logic        sh_gate;
    logic [7:0]  sar_code;
    logic [1:0]  irq_flag;
    logic [3:0]  pin_dig_en;
    logic        cmp_in;

    logic [7:0]  lvl [4];
    logic [31:0] exp_q [$];
    int          n_chk = 0;
    int          n_err = 0;
    bit          sb_on = 1'b0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    // Comparator model: selected level at or above the DAC code.
    assign cmp_in = (lvl[mux_sel] >= sar_code);

    scan_sar_ctrl #(.CYC_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .cmp_in(cmp_in), .dig_in(dig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .mux_sel(mux_sel), .sh_gate(sh_gate),
        .sar_code(sar_code), .irq_flag(irq_flag), .pin_dig_en(pin_dig_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.2;
        d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Wait until the first negedge at which mux_sel shows channel c.
    task automatic wait_ch(input logic [1:0] c);
        logic [1:0] prev;
        prev = mux_sel;
        forever begin
            @(negedge clk);
            if (mux_sel == c && prev != c) break;
            prev = mux_sel;
        end
    endtask

    // Driver: set the four levels and queue the expected scan result.
    task automatic drive_scan(input logic [7:0] a, input logic [7:0] b,
                              input logic [7:0] c, input logic [7:0] d);
        lvl[0] = a; lvl[1] = b; lvl[2] = c; lvl[3] = d;
        exp_q.push_back({d, c, b, a});
    endtask

    // Monitor: at every scan boundary compare both result words and flags.
    initial begin
        logic [1:0]  prev;
        logic [31:0] e;
        logic [15:0] v;
        prev = 2'd0;
        forever begin
            @(negedge clk);
            if (sb_on && prev == 2'd3 && mux_sel == 2'd0 && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                rd(2'd0, v);
                chk(v == e[15:0], "R6/R5 word0", {16'h0, v}, {16'h0, e[15:0]});
                rd(2'd1, v);
                chk(v == e[31:16], "R6/R7 word1", {16'h0, v}, {16'h0, e[31:16]});
                chk(irq_flag == 2'b11, "R8 flags at scan end", {30'h0, irq_flag}, 32'h3);
            end
            prev = mux_sel;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int          cnt;
        lvl[0] = 8'h0; lvl[1] = 8'h0; lvl[2] = 8'h0; lvl[3] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == 16'h0, "R1 word0", {16'h0, v}, 32'h0);
        rd(2'd1, v); chk(v == 16'h0, "R1 word1", {16'h0, v}, 32'h0);
        rd(2'd2, v); chk(v == 16'h0, "R1 flags", {16'h0, v}, 32'h0);
        chk(mux_sel == 0 && !sh_gate && sar_code == 0 && pin_dig_en == 0,
            "R1 outputs", {22'h0, mux_sel, sh_gate, sar_code}, 32'h0);

        // R10 mask write and gated pin readback
        dig_in = 4'b0110;
        wr(2'd3, 16'h0005);
        rd(2'd3, v); chk(v == 16'h0045, "R10 mask readback", {16'h0, v}, 32'h45);
        chk(pin_dig_en == 4'h5, "R10 pin enable", {28'h0, pin_dig_en}, 32'h5);

        // Scoreboard phase: R5, R6, R7, R8
        sb_on = 1'b1;
        drive_scan(8'h3C, 8'hA5, 8'h00, 8'hFF);
        run = 1'b1;
        @(negedge clk);
        chk(sh_gate && mux_sel == 0, "R2 start on ch0", {30'h0, mux_sel, sh_gate}, 32'h1);
        wait_ch(2'd0); @(negedge clk);
        drive_scan(8'h80, 8'h7F, 8'h01, 8'hFE);
        wait_ch(2'd0); @(negedge clk);
        drive_scan(8'h12, 8'h34, 8'h56, 8'h78);
        wait_ch(2'd0); @(negedge clk);
        drive_scan(8'hFF, 8'h00, 8'hC3, 8'h81);
        wait_ch(2'd0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R7 all scans seen", exp_q.size(), 0);
        sb_on = 1'b0;

        // R6 byte-granular update, R4 gate window, R5 first trials, R3 slot length
        lvl[0] = 8'h11; lvl[1] = 8'h22; lvl[2] = 8'h33; lvl[3] = 8'h44;
        wait_ch(2'd1);
        rd(2'd0, v); chk(v == 16'h0011, "R6 only ch0 byte new", {16'h0, v}, 32'h11);
        rd(2'd1, v); chk(v == 16'h81C3, "R6 word1 untouched", {16'h0, v}, 32'h81C3);
        chk(sh_gate && sar_code == 0, "R4 gate open at slot start", {23'h0, sh_gate, sar_code}, 32'h100);
        cnt = 0;
        repeat (S_CYC - 1) begin @(negedge clk); cnt++; end
        chk(sh_gate, "R4 gate open last sample cycle", {31'h0, sh_gate}, 32'h1);
        @(negedge clk); cnt++;
        chk(!sh_gate && sar_code == 8'h80, "R5 MSB trial", {23'h0, sh_gate, sar_code}, 32'h80);
        repeat (T_CYC) begin @(negedge clk); cnt++; end
        chk(sar_code == 8'h40, "R5 MSB cleared next set", {24'h0, sar_code}, 32'h40);
        while (mux_sel == 2'd1) begin @(negedge clk); cnt++; end
        chk(cnt == SLOT && mux_sel == 2'd2, "R3 slot length and order", cnt, SLOT);

        // R9 selective clear and write of zero
        wr(2'd2, 16'h0001);
        chk(irq_flag == 2'b10, "R9 clear bit0 only", {30'h0, irq_flag}, 32'h2);
        wr(2'd2, 16'h0000);
        chk(irq_flag == 2'b10, "R9 zero write no effect", {30'h0, irq_flag}, 32'h2);
        wr(2'd2, 16'h0002);
        chk(irq_flag == 2'b00, "R9 clear bit1", {30'h0, irq_flag}, 32'h0);

        // R8 set timing and R9 set-over-clear collision
        wait_ch(2'd3);
        repeat (FLAG_C) @(negedge clk);
        chk(irq_flag == 2'b00, "R8 flags not yet set", {30'h0, irq_flag}, 32'h0);
        wr(2'd2, 16'h0003);
        chk(irq_flag == 2'b11, "R9 set wins over clear", {30'h0, irq_flag}, 32'h3);
        rd(2'd2, v); chk(v == 16'h0003, "R8 flags readback", {16'h0, v}, 32'h3);
        rd(2'd1, v); chk(v == 16'h4433, "R6 word1 after ch3", {16'h0, v}, 32'h4433);

        // R2 parking while run is low
        run = 1'b0;
        lvl[0] = 8'hEE;
        @(negedge clk);
        chk(mux_sel == 0 && !sh_gate && sar_code == 0, "R2 parked",
            {22'h0, mux_sel, sh_gate, sar_code}, 32'h0);
        repeat (3 * SLOT) @(negedge clk);
        rd(2'd0, v); chk(v == 16'h2211, "R2 results held", {16'h0, v}, 32'h2211);
        chk(mux_sel == 0, "R2 still ch0", {30'h0, mux_sel}, 32'h0);
        run = 1'b1;
        @(negedge clk);
        chk(sh_gate && mux_sel == 0, "R2 restart at ch0", {30'h0, mux_sel, sh_gate}, 32'h1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule